// File: doc/BRIEF.md
# Late-Write SRAM Front-End with Write Bypass

This block sits in front of a synchronous storage array. It accepts a command on a rising clock edge and then runs the data phase of that command. A command is either a read or a write. It moves one word per clock (single-rate) or two words per clock, one on each clock phase (double-rate), in bursts of up to four words. The burst walks the two low address bits in either interleaved or linear order.

Writes are late. The data follows its command by one cycle and is parked in a pending buffer together with its beat addresses. Nothing reaches the array until the next write command is accepted, which flushes the parked burst into the array. A read that names an address still parked in the buffer is answered from the buffer. The decision is made separately for each beat of the read. After reset the buffer holds nothing valid.

The read path drives the data bus only during its own data beats. A simple turnaround monitor raises an error pulse when a write follows a read too closely.

Top module: `latewr_sram_fe`

## Requirements
- R1: A read accepted at rising edge k presents its first word from edge k+1 with `rdata_oe` high. In single-rate mode a burst of L words delivers one word per cycle for L cycles.
- R2: With `cmd_ddr`=1 a read delivers two words per cycle. The even beat is shown while the clock is high after the rising edge, and the odd beat is shown during the low half that follows.
- R3: Burst length `cmd_blen` is coded 00=1, 01=2, 1x=4 words, and a double-rate command always moves at least 2. Beat i keeps the upper address bits of the base. Its two low bits are base XOR i when `cmd_linear`=0, and base plus i modulo 4 when `cmd_linear`=1.
- R4: For a write accepted at edge k, single-rate beat i is sampled from `wdata` at rising edge k+1+i. In double-rate mode beat 2j is sampled at rising edge k+1+j and beat 2j+1 at the falling edge right after it.
- R5: Written data is stored in the array only when the next write command is accepted. At that point every beat of the parked burst is stored.
- R6: A read beat whose address matches a parked write beat returns the parked word, and the other beats of the same burst come from the array.
- R7: Reset discards the parked burst. No bypass hit occurs afterwards, and the first write after reset stores nothing in the array.
- R8: A command occupies the block during its data cycles (edges k+1 to k+C, where C is the word count, halved in double-rate mode). A command presented at those edges is ignored.
- R9: Once a read's data cycles are over, two idle edges with `cmd_valid` low are required before a write. A write accepted sooner raises `proto_err` for the one cycle after its accepting edge, and it is still carried out.
- R10: `rdata_oe` is high only in read data cycles, and `rdata` is zero whenever `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges move double-rate data |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this edge |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_ddr | input | 1 | 1 = two words per clock |
| cmd_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| cmd_blen | input | 2 | Burst length code |
| cmd_addr | input | AW | Burst base address |
| wdata | input | DW | Write data beats |
| rdata | output | DW | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data output enable |
| proto_err | output | 1 | Read-to-write turnaround violation pulse |

## Verification
The hardest state to reach is a single double-rate burst whose beats split between the array and the parked buffer. The bench first writes two neighbouring addresses, then issues a write to only one of them, which flushes the pair and parks the new word. A double-rate read across both addresses then has to take its rising-phase word from the array and its falling-phase word from the buffer. Whether parked data has really stayed out of the array is invisible while bypass hides it. A reset placed between an overwrite and its read exposes the array contents for that check.

// File: rtl/latewr_sram_fe.sv
`timescale 1ns/1ps
module latewr_sram_fe #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          cmd_ddr,
  input  logic          cmd_linear,
  input  logic [1:0]    cmd_blen,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe,
  output logic          proto_err
);
  localparam int DEPTH = 1 << AW;
  localparam int NB    = 4;

  logic [DW-1:0] mem [DEPTH];

  logic [2:0]    cyc_left, cyc_tot;
  logic          op_wr, op_ddr, op_lin;
  logic [AW-1:0] op_base;

  logic [AW-1:0] p_addr [NB];
  logic [DW-1:0] p_rise [NB];
  logic [DW-1:0] p_fall [NB];
  logic [NB-1:0] p_vld, p_src_fall;
  logic          fall_en;
  logic [1:0]    fall_slot;

  logic [DW-1:0] q_r, q_f;
  logic          q_oe, q_ddr;
  logic [1:0]    gap;
  logic          rd_seen;

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base,
                                              input logic lin, input logic [1:0] i);
    beat_addr = {base[AW-1:2], lin ? base[1:0] + i : base[1:0] ^ i};
  endfunction

  wire idle   = (cyc_left == 3'd0);
  wire accept = cmd_valid && idle;

  logic [2:0] n_beats, n_cyc;
  assign n_beats = cmd_blen[1] ? 3'd4 : (cmd_blen[0] || cmd_ddr) ? 3'd2 : 3'd1;
  assign n_cyc   = cmd_ddr ? (n_beats >> 1) : n_beats;

  logic [1:0] idx, beat_r, beat_f;
  assign idx    = 2'(cyc_tot - cyc_left);
  assign beat_r = op_ddr ? {idx[0], 1'b0} : idx;
  assign beat_f = {idx[0], 1'b1};

  logic [AW-1:0] addr_r, addr_f;
  assign addr_r = beat_addr(op_base, op_lin, beat_r);
  assign addr_f = beat_addr(op_base, op_lin, beat_f);

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_left <= '0;
      cyc_tot  <= '0;
      op_wr    <= 1'b0;
      op_ddr   <= 1'b0;
      op_lin   <= 1'b0;
      op_base  <= '0;
    end else if (accept) begin
      cyc_left <= n_cyc;
      cyc_tot  <= n_cyc;
      op_wr    <= cmd_write;
      op_ddr   <= cmd_ddr;
      op_lin   <= cmd_linear;
      op_base  <= cmd_addr;
    end else if (!idle) begin
      cyc_left <= cyc_left - 3'd1;
    end
  end

  // flush of the parked burst into the array
  always_ff @(posedge clk) begin
    if (accept && cmd_write)
      for (int s = 0; s < NB; s++)
        if (p_vld[s]) mem[p_addr[s]] <= p_src_fall[s] ? p_fall[s] : p_rise[s];
  end

  // parked burst: addresses and validity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld      <= '0;
      p_src_fall <= '0;
      for (int s = 0; s < NB; s++) p_addr[s] <= '0;
      fall_en    <= 1'b0;
      fall_slot  <= '0;
    end else begin
      if (accept && cmd_write)
        for (int s = 0; s < NB; s++) begin
          p_vld[s]      <= 3'(s) < n_beats;
          p_src_fall[s] <= cmd_ddr && (s % 2 == 1);
          p_addr[s]     <= beat_addr(cmd_addr, cmd_linear, 2'(s));
        end
      fall_en   <= !idle && op_wr && op_ddr;
      fall_slot <= beat_f;
    end
  end

  always_ff @(posedge clk)
    if (!idle && op_wr) p_rise[beat_r] <= wdata;

  always_ff @(negedge clk)
    if (fall_en) p_fall[fall_slot] <= wdata;

  // array read with per-beat bypass
  logic [DW-1:0] rd_r, rd_f;
  always_comb begin
    rd_r = mem[addr_r];
    rd_f = mem[addr_f];
    for (int s = 0; s < NB; s++) begin
      if (p_vld[s] && p_addr[s] == addr_r) rd_r = p_src_fall[s] ? p_fall[s] : p_rise[s];
      if (p_vld[s] && p_addr[s] == addr_f) rd_f = p_src_fall[s] ? p_fall[s] : p_rise[s];
    end
  end

  // output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      q_f   <= '0;
      q_oe  <= 1'b0;
      q_ddr <= 1'b0;
    end else begin
      q_oe  <= !idle && !op_wr;
      q_ddr <= op_ddr;
      if (!idle && !op_wr) begin
        q_r <= rd_r;
        q_f <= rd_f;
      end
    end
  end

  assign rdata    = q_oe ? ((q_ddr && !clk) ? q_f : q_r) : '0;
  assign rdata_oe = q_oe;

  // read-to-write turnaround monitor
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '0;
      rd_seen   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (accept && !cmd_write) begin
        gap     <= '0;
        rd_seen <= 1'b1;
      end else if (idle && !cmd_valid && gap != 2'd2) begin
        gap <= gap + 2'd1;
      end
      proto_err <= accept && cmd_write && rd_seen && (gap < 2'd2);
    end
  end

  // R1
  rd_oe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata_oe) |-> $past(cmd_valid && !cmd_write, 2));

  // R10
  no_oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && op_wr) |=> !rdata_oe);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(op_base) && $stable(op_wr) && $stable(op_ddr)));

  // R7
  pend_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|p_vld) |-> $past(cmd_valid && cmd_write));

  // R9
  proto_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(cmd_valid && cmd_write));

  // R10
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));
endmodule

// File: tb/latewr_sram_fe_bench.sv
`timescale 1ns/1ps
module latewr_sram_fe_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_ddr = 1'b0, cmd_linear = 1'b0;
  logic [1:0]  cmd_blen = '0;
  logic [5:0]  cmd_addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rdata_oe, proto_err;

  int n_chk = 0, n_fail = 0;
  logic last_perr;

  latewr_sram_fe #(.AW(6), .DW(16)) u_latewr_sram_fe (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_ddr(cmd_ddr), .cmd_linear(cmd_linear), .cmd_blen(cmd_blen),
    .cmd_addr(cmd_addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .proto_err(proto_err));

  always #10 clk = ~clk;

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int words(logic ddr, logic [1:0] bl);
    return bl[1] ? 4 : (bl[0] || ddr) ? 2 : 1;
  endfunction

  task automatic issue(logic wr, logic ddr, logic lin, logic [1:0] bl, logic [5:0] a);
    cmd_valid = 1'b1; cmd_write = wr; cmd_ddr = ddr; cmd_linear = lin;
    cmd_blen = bl; cmd_addr = a;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic wr(logic ddr, logic lin, logic [1:0] bl, logic [5:0] a, logic [63:0] d);
    int nb = words(ddr, bl);
    issue(1'b1, ddr, lin, bl, a);
    last_perr = proto_err;
    if (!ddr) begin
      for (int i = 0; i < nb; i++) begin
        wdata = d[16*i +: 16];
        step();
      end
    end else begin
      wdata = d[15:0];
      step();
      wdata = d[31:16];
      if (nb == 4) begin
        #10 wdata = d[47:32];
        step();
        wdata = d[63:48];
      end
    end
  endtask

  task automatic rd(string req, logic ddr, logic lin, logic [1:0] bl, logic [5:0] a,
                    logic [63:0] exp, int nchk);
    int nb = words(ddr, bl);
    int nc = ddr ? nb / 2 : nb;
    issue(1'b0, ddr, lin, bl, a);
    for (int j = 0; j < nc; j++) begin
      step();
      check("R1", "read enable", {15'd0, rdata_oe}, 16'd1);
      if (ddr) begin
        if (2*j < nchk)   check(req, "rise word", rdata, exp[32*j +: 16]);
        #10;
        if (2*j+1 < nchk) check(req, "fall word", rdata, exp[32*j+16 +: 16]);
      end else if (j < nchk) begin
        check(req, "word", rdata, exp[16*j +: 16]);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset_state();
    check("R10", "oe after reset", {15'd0, rdata_oe}, 16'd0);
    check("R10", "rdata after reset", rdata, 16'd0);
    check("R9", "perr after reset", {15'd0, proto_err}, 16'd0);
  endtask

  task automatic t_simple_bypass();
    wr(0, 0, 2'b00, 6'd5, 64'h1111);
    rd("R6", 0, 0, 2'b00, 6'd5, 64'h1111, 1);
  endtask

  task automatic t_late_commit_reset();
    wr(0, 0, 2'b00, 6'd5, 64'hA1A1);
    wr(0, 0, 2'b00, 6'd6, 64'hB2B2);
    wr(0, 0, 2'b00, 6'd5, 64'hC3C3);
    rd("R6", 0, 0, 2'b00, 6'd5, 64'hC3C3, 1);
    do_reset();
    rd("R5", 0, 0, 2'b00, 6'd5, 64'hA1A1, 1);
    rd("R5", 0, 0, 2'b00, 6'd6, 64'hB2B2, 1);
    wr(0, 0, 2'b00, 6'd9, 64'hD4D4);
    wr(0, 0, 2'b00, 6'd10, 64'hE5E5);
    rd("R7", 0, 0, 2'b00, 6'd5, 64'hA1A1, 1);
    rd("R7", 0, 0, 2'b00, 6'd9, 64'hD4D4, 1);
  endtask

  task automatic t_burst_order();
    // interleaved from 0x12: 0x12,0x13,0x10,0x11
    wr(0, 0, 2'b10, 6'h12, {16'h1003, 16'h1002, 16'h1001, 16'h1000});
    rd("R3", 0, 1, 2'b10, 6'h10, {16'h1001, 16'h1000, 16'h1003, 16'h1002}, 4);
    rd("R3", 0, 1, 2'b10, 6'h13, {16'h1000, 16'h1003, 16'h1002, 16'h1001}, 4);
    rd("R3", 0, 0, 2'b10, 6'h11, {16'h1000, 16'h1001, 16'h1002, 16'h1003}, 4);
  endtask

  task automatic t_split_bypass();
    wr(0, 1, 2'b01, 6'h21, {32'h0, 16'h2202, 16'h2101});
    wr(0, 0, 2'b00, 6'h22, 64'h5A5A);
    rd("R6", 1, 1, 2'b01, 6'h21, {32'h0, 16'h5A5A, 16'h2101}, 2);
  endtask

  task automatic t_ddr_write();
    // interleaved from 0x31: 0x31,0x30,0x33,0x32
    wr(1, 0, 2'b10, 6'h31, {16'hD003, 16'hD002, 16'hD001, 16'hD000});
    wr(0, 0, 2'b00, 6'h3F, 64'hFFFF);
    rd("R4", 1, 1, 2'b10, 6'h30, {16'hD002, 16'hD003, 16'hD000, 16'hD001}, 4);
    rd("R2", 1, 0, 2'b00, 6'h32, {32'h0, 16'hD002, 16'hD003}, 2);
  endtask

  task automatic t_busy_ignore();
    wr(0, 0, 2'b00, 6'h10, 64'h5050);
    issue(1'b0, 0, 1, 2'b01, 6'h10);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 6'h10; cmd_blen = 2'b00; wdata = 16'hDEAD;
    step();
    check("R8", "first beat while busy", rdata, 16'h5050);
    step();
    check("R8", "oe second beat", {15'd0, rdata_oe}, 16'd1);
    cmd_valid = 1'b0;
    step();
    check("R10", "oe after burst", {15'd0, rdata_oe}, 16'd0);
    check("R10", "rdata after burst", rdata, 16'd0);
    check("R8", "no error from ignored write", {15'd0, proto_err}, 16'd0);
    rd("R8", 0, 0, 2'b00, 6'h10, 64'h5050, 1);
  endtask

  task automatic t_turnaround();
    wr(0, 0, 2'b00, 6'h20, 64'h6060);
    check("R9", "error on immediate write", {15'd0, last_perr}, 16'd1);
    check("R9", "error is one cycle", {15'd0, proto_err}, 16'd0);
    check("R10", "oe during write data", {15'd0, rdata_oe}, 16'd0);
    step(); step();
    rd("R9", 0, 0, 2'b00, 6'h20, 64'h6060, 1);
    step(); step();
    wr(0, 0, 2'b00, 6'h21, 64'h6161);
    check("R9", "no error after two idles", {15'd0, last_perr}, 16'd0);
    step(); step();
    rd("R9", 0, 0, 2'b00, 6'h21, 64'h6161, 1);
    step();
    wr(0, 0, 2'b00, 6'h22, 64'h6262);
    check("R9", "error after one idle", {15'd0, last_perr}, 16'd1);
  endtask

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_simple_bypass();
    t_late_commit_reset();
    t_burst_order();
    t_split_bypass();
    t_ddr_write();
    t_busy_ignore();
    t_turnaround();
    step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule